// File: doc/BRIEF.md
# Lexicographic Floating-Point Compare

This block orders two IEEE-754 operands, either single or double precision, and returns a 2-bit code. The ordering is total. Negative zero sorts below positive zero. NaN operands do not produce a single "unordered" answer; each case gets its own code, depending on which side holds the NaN.

The block has no status or flag outputs, so it can never signal an exception. A compare has no side effect beyond the code it returns. Signaling and quiet NaNs are handled identically.

A precision select chooses the operand width. In single-precision mode only the low 32 bits of each operand are used. A parameter chooses between a purely combinational result and a registered result with one cycle of latency.

Top module: `lex_fp_compare`

## Requirements
- R1: When the second operand (`opb`) is a NaN (exponent all ones, fraction nonzero), the code is 3, whatever the first operand holds.
- R2: When `opa` is a NaN and `opb` is not, the code is 2.
- R3: When both operands are non-NaN and `opa` is numerically below `opb`, the code is 1.
- R4: When both operands are non-NaN and `opa` is numerically above `opb`, the code is 0.
- R5: Bit-identical non-NaN operands give code 0. This includes +0 with +0 and -0 with -0.
- R6: `opa` = -0 with `opb` = +0 gives code 1. `opa` = +0 with `opb` = -0 gives code 0.
- R7: Signaling NaNs (fraction MSB clear) and quiet NaNs (fraction MSB set) of either sign give the same codes under R1 and R2.
- R8: With `dbl_sel` = 0, operands are single precision in bits [31:0], and bits [63:32] have no effect on the code. With `dbl_sel` = 1, all 64 bits form a double.
- R9: With `REG_OUT` = 1, the code reflects the inputs sampled at the previous rising clock edge, and it is 0 while `rst_n` is low. With `REG_OUT` = 0, the code follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision in bits [31:0] |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| code | output | 2 | 0 = above or equal, 1 = below, 2 = only `opa` NaN, 3 = `opb` NaN |

## Verification
The bench crosses every pair from a set of signed zeros, subnormals, normals, extremes, infinities and NaNs of both kinds and signs, in both precisions. It runs the sweep once with garbage in the upper half during single-precision mode.

The corner cases it targets, and how a faulty design would show up:
- A design that compares zeros only by magnitude would return 0 for -0 against +0.
- A design that checks the first operand's NaN first would return 2 where both operands are NaN.
- A design that tests only the quiet bit would treat signaling NaNs as huge numbers.
- A design that decodes the wrong width would be upset by the upper-half garbage.

The bench also checks that the registered output holds its old value until the clock edge.

// File: rtl/lex_fp_compare.sv
module lex_fp_compare #(
  parameter int  SP_EXP  = 8,
  parameter int  SP_W    = 32,
  parameter int  DP_EXP  = 11,
  parameter int  DP_W    = 64,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbl_sel,
  input  logic [DP_W-1:0] opa,
  input  logic [DP_W-1:0] opb,
  output logic [1:0]      code
);
  localparam int SP_FRAC = SP_W - 1 - SP_EXP;
  localparam int DP_FRAC = DP_W - 1 - DP_EXP;

  logic sp_a_nan, sp_b_nan, dp_a_nan, dp_b_nan;
  assign sp_a_nan = (&opa[SP_W-2 -: SP_EXP]) && (|opa[SP_FRAC-1:0]);
  assign sp_b_nan = (&opb[SP_W-2 -: SP_EXP]) && (|opb[SP_FRAC-1:0]);
  assign dp_a_nan = (&opa[DP_W-2 -: DP_EXP]) && (|opa[DP_FRAC-1:0]);
  assign dp_b_nan = (&opb[DP_W-2 -: DP_EXP]) && (|opb[DP_FRAC-1:0]);

  // sign-magnitude mapped onto an unsigned key; -0 lands just below +0
  logic [SP_W-1:0] sp_ka, sp_kb;
  logic [DP_W-1:0] dp_ka, dp_kb;
  assign sp_ka = opa[SP_W-1] ? ~opa[SP_W-1:0] : {1'b1, opa[SP_W-2:0]};
  assign sp_kb = opb[SP_W-1] ? ~opb[SP_W-1:0] : {1'b1, opb[SP_W-2:0]};
  assign dp_ka = opa[DP_W-1] ? ~opa : {1'b1, opa[DP_W-2:0]};
  assign dp_kb = opb[DP_W-1] ? ~opb : {1'b1, opb[DP_W-2:0]};

  logic a_nan, b_nan, below;
  assign a_nan = dbl_sel ? dp_a_nan : sp_a_nan;
  assign b_nan = dbl_sel ? dp_b_nan : sp_b_nan;
  assign below = dbl_sel ? (dp_ka < dp_kb) : (sp_ka < sp_kb);

  logic [1:0] code_c;
  assign code_c = b_nan ? 2'd3 : a_nan ? 2'd2 : {1'b0, below};

  generate
    if (REG_OUT) begin : g_reg
      logic [1:0] code_q;
      always_ff @(posedge clk) begin
        if (!rst_n) code_q <= 2'd0;
        else        code_q <= code_c;
      end
      assign code = code_q;

      a_r1_b_nan_three: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_sel && (&opb[30:23]) && (|opb[22:0])) |=> code == 2'd3);
      a_r2_a_nan_two: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_sel && (&opa[62:52]) && (|opa[51:0]) && !((&opb[62:52]) && (|opb[51:0])))
        |=> code == 2'd2);
      a_r5_identical_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_sel && opa[31:0] == opb[31:0] && !((&opb[30:23]) && (|opb[22:0])))
        |=> code == 2'd0);
      a_r6_negzero_below: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_sel && opa[31:0] == 32'h8000_0000 && opb[31:0] == 32'h0) |=> code == 2'd1);
    end else begin : g_comb
      assign code = code_c;
    end
  endgenerate
endmodule

// File: tb/lex_fp_compare_bench.sv
`timescale 1ns/1ps
module lex_fp_compare_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbl_sel = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [1:0] code_r, code_c;
  int n_vec = 0, n_bad = 0;
  logic [1:0] prev_exp = 2'd0;

  always #2 clk = ~clk;

  lex_fp_compare #(.REG_OUT(1'b1)) u_lex_fp_compare (
    .clk(clk), .rst_n(rst_n), .dbl_sel(dbl_sel), .opa(opa), .opb(opb), .code(code_r));
  lex_fp_compare #(.REG_OUT(1'b0)) u_lex_fp_compare_comb (
    .clk(clk), .rst_n(rst_n), .dbl_sel(dbl_sel), .opa(opa), .opb(opb), .code(code_c));

  function automatic logic [31:0] sp_val(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h0000_0001;  3: return 32'h8000_0001;
      4: return 32'h3F80_0000;  5: return 32'hBF80_0000;
      6: return 32'h3FC0_0000;  7: return 32'h4000_0000;
      8: return 32'hC000_0000;  9: return 32'h7F7F_FFFF;
      10: return 32'h7F80_0000; 11: return 32'hFF80_0000;
      12: return 32'h7FC0_0000; 13: return 32'h7F80_0001;
      14: return 32'hFFC0_0001; default: return 32'h0080_0000;
    endcase
  endfunction

  function automatic logic [63:0] dp_val(int i);
    case (i)
      0: return 64'h0;                    1: return 64'h8000_0000_0000_0000;
      2: return 64'h0000_0000_0000_0001;  3: return 64'h8000_0000_0000_0001;
      4: return 64'h3FF0_0000_0000_0000;  5: return 64'hBFF0_0000_0000_0000;
      6: return 64'h3FF8_0000_0000_0000;  7: return 64'h4000_0000_0000_0000;
      8: return 64'hC000_0000_0000_0000;  9: return 64'h7FEF_FFFF_FFFF_FFFF;
      10: return 64'h7FF0_0000_0000_0000; 11: return 64'hFFF0_0000_0000_0000;
      12: return 64'h7FF8_0000_0000_0000; 13: return 64'h7FF0_0000_0000_0001;
      14: return 64'hFFF8_0000_0000_0001; default: return 64'h0010_0000_0000_0000;
    endcase
  endfunction

  function automatic real sp_real(logic [31:0] x);
    real m;
    int e = int'(x[30:23]);
    if (e == 255) m = 1.0e300;
    else if (e == 0) m = real'(x[22:0]) * (2.0 ** (-149));
    else m = real'({1'b1, x[22:0]}) * (2.0 ** (e - 150));
    return x[31] ? -m : m;
  endfunction

  function automatic logic [1:0] expect_code(logic d, logic [63:0] a, logic [63:0] b,
                                             output string tag);
    logic an, bn, az, bz;
    real ra, rb;
    if (d) begin
      an = (&a[62:52]) && (|a[51:0]); bn = (&b[62:52]) && (|b[51:0]);
      az = a[62:0] == 0; bz = b[62:0] == 0;
      ra = $bitstoreal(a); rb = $bitstoreal(b);
    end else begin
      an = (&a[30:23]) && (|a[22:0]); bn = (&b[30:23]) && (|b[22:0]);
      az = a[30:0] == 0; bz = b[30:0] == 0;
      ra = sp_real(a[31:0]); rb = sp_real(b[31:0]);
    end
    if (bn) begin tag = an ? "R1/R7" : "R1"; return 2'd3; end
    if (an) begin tag = "R2/R7"; return 2'd2; end
    if (az && bz) begin tag = "R6/R5"; return (d ? a[63] : a[31]) && !(d ? b[63] : b[31]) ? 2'd1 : 2'd0; end
    if (ra < rb) begin tag = "R3"; return 2'd1; end
    tag = (ra > rb) ? "R4" : "R5";
    return 2'd0;
  endfunction

  task automatic apply(logic d, logic [63:0] a, logic [63:0] b);
    string tag;
    logic [1:0] e;
    @(negedge clk);
    dbl_sel = d; opa = a; opb = b;
    e = expect_code(d, a, b, tag);
    if (!d) tag = {tag, "/R8"};
    #1;
    n_vec++;
    if (code_r !== prev_exp) begin
      n_bad++;
      $display("FAIL R9 latency hold a=%h b=%h got %0d exp %0d", a, b, code_r, prev_exp);
    end
    n_vec++;
    if (code_c !== e) begin
      n_bad++;
      $display("FAIL %s comb d=%0b a=%h b=%h got %0d exp %0d", tag, d, a, b, code_c, e);
    end
    @(negedge clk);
    n_vec++;
    if (code_r !== e) begin
      n_bad++;
      $display("FAIL %s/R9 reg d=%0b a=%h b=%h got %0d exp %0d", tag, d, a, b, code_r, e);
    end
    prev_exp = e;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    opa = 64'h7FF8_0000_0000_0000; opb = 64'h3FF0_0000_0000_0000; dbl_sel = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (code_r !== 2'd0) begin
      n_bad++;
      $display("FAIL R9 reset got %0d exp 0", code_r);
    end
    rst_n = 1'b1;
    @(negedge clk);
    prev_exp = 2'd2;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        apply(1'b1, dp_val(i), dp_val(j));
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        apply(1'b0, {32'h0, sp_val(i)}, {32'h0, sp_val(j)});
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        apply(1'b0, {32'hFFF8_0001, sp_val(i)}, {32'h7FF0_0001, sp_val(j)});
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule